// File: doc/BRIEF.md
# Vector FMA Operand Steering and Masked Writeback

This block sits between the issue logic and a row of 64-bit lane arithmetic units of a packed double-precision fused multiply-add. It accepts one request at a time. A request carries a form code, a vector length, the old destination value, two source vectors, flags for a memory third source and for scalar broadcast, an 8-bit lane mask with enable and merge/zero select, and two rounding-mode values. From these it builds the multiplicand, multiplier and addend for each lane and picks the rounding mode. It then issues the lanes that need arithmetic.

Lane units return results on input ports, in any order and over any number of cycles. When every issued lane has returned, the block forms the new destination. Lanes that were issued take their result. Lanes that were masked off keep the old value or become zero. Everything above the active length is cleared. The block then pulses `done`. The arithmetic itself is outside the block.

Top module: `vfma_steer_wb`

## Requirements
- R1: Form code 0x98 routes multiplicand = destination lane, multiplier = third-source lane, addend = second-source lane.
- R2: Form code 0xA8 routes multiplicand = second-source lane, multiplier = destination lane, addend = third-source lane.
- R3: Form code 0xB8 routes multiplicand = second-source lane, multiplier = third-source lane, addend = destination lane.
- R4: `vlen_sel` 00, 01 and 10 select 2, 4 and 8 active lanes. A lane is issued when it is active and either its mask bit is set or `mask_en` is 0.
  - `lane_go` shows exactly the issued lanes for the one cycle after acceptance, and is zero at all other times.
  - Operand lanes that are not issued read zero. Operands are held while busy.
- R5: An active lane that is not issued becomes zero when `zero_mode` is 1, and keeps its old destination value when `zero_mode` is 0.
- R6: In `dst_out`, lanes at and above the active count are zero. Result ports of lanes that were not issued are ignored, whatever their valid bits.
- R7: With `mem_src`=1 and `bcast`=1, bits [63:0] of the third source feed every lane. With `mem_src`=0, `bcast` causes no broadcast.
- R8: `lane_rm` equals `rc_embed` when `mem_src`=0, `bcast`=1 and the length is 512, and equals `rc_global` in every other case.
  - The mode encoding is 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
  - The same value goes to all lanes.
- R9: `req_ready` is high when idle, and a request is accepted on `req_valid` && `req_ready`. `req_ready` stays low until completion. Requests and input changes made while busy have no effect on the running operation.
- R10: Each issued lane's result is taken on the first cycle its `lane_res_vld` bit is high, from the `lane_go` cycle on, in any order.
  - `dst_out` updates at the edge where the last issued result is present, and `done` is high for exactly the following cycle.
  - With no lane issued, `done` follows the `lane_go` cycle.
- R11: After reset, `req_ready`=1, `done`=0, `lane_go`=0 and `dst_out`=0.
- R12: Mask bits at and above the active lane count have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| form_code | input | 8 | Operand form: 0x98, 0xA8 or 0xB8 |
| vlen_sel | input | 2 | 00: 128, 01: 256, 10: 512 bits |
| dst_in | input | 512 | Old destination value |
| src2_in | input | 512 | Second source vector |
| src3_in | input | 512 | Third source vector |
| bcast | input | 1 | Broadcast / embedded-control flag |
| mem_src | input | 1 | Third source came from memory |
| mask | input | 8 | Per-lane write mask |
| mask_en | input | 1 | Masking enabled |
| zero_mode | input | 1 | 1: zero unmasked lanes, 0: merge |
| rc_embed | input | 2 | Rounding mode carried by the request |
| rc_global | input | 2 | Rounding mode from the control register |
| lane_go | output | 8 | Issue strobe per lane |
| lane_a | output | 512 | Multiplicand per lane |
| lane_b | output | 512 | Multiplier per lane |
| lane_c | output | 512 | Addend per lane |
| lane_rm | output | 2 | Rounding mode for all lanes |
| lane_res | input | 512 | Lane results |
| lane_res_vld | input | 8 | Lane result valid |
| done | output | 1 | One-cycle completion pulse |
| dst_out | output | 512 | New destination value |

## Verification
The assertions take for granted that an accepted request never carries `vlen_sel`=11 and that its form code is one of the three legal bytes. A dedicated property flags either case. The stimulus stays within these limits because every request comes from a fixed table built only from legal codes and lengths. The lane model returns results only for lanes that were issued. It may still raise valid bits on other lanes, and these must be ignored.

// File: rtl/vfma_pkg.sv
package vfma_pkg;

    localparam logic [7:0] OPC_132 = 8'h98;
    localparam logic [7:0] OPC_213 = 8'hA8;
    localparam logic [7:0] OPC_231 = 8'hB8;

    typedef enum logic [1:0] {
        FM_132 = 2'd0,
        FM_213 = 2'd1,
        FM_231 = 2'd2
    } form_e;

    localparam logic [1:0] VL_128 = 2'b00;
    localparam logic [1:0] VL_256 = 2'b01;
    localparam logic [1:0] VL_512 = 2'b10;

    // latched request context
    typedef struct packed {
        form_e      form;
        logic       zero_mode;
        logic [1:0] rm;
    } ctx_t;

    function automatic form_e form_of(input logic [7:0] code);
        case (code)
            OPC_213: return FM_213;
            OPC_231: return FM_231;
            default: return FM_132;
        endcase
    endfunction

    function automatic int unsigned lanes_of(input logic [1:0] vl);
        case (vl)
            VL_128:  return 2;
            VL_256:  return 4;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/vfma_req_decode.sv
module vfma_req_decode
    import vfma_pkg::*;
#(
    parameter int LANES = 8,
    parameter int LW    = 64,
    localparam int VW   = LANES * LW
) (
    input  logic [7:0]       form_code,
    input  logic [1:0]       vlen_sel,
    input  logic             bcast,
    input  logic             mem_src,
    input  logic [LANES-1:0] mask,
    input  logic             mask_en,
    input  logic [1:0]       rc_embed,
    input  logic [1:0]       rc_global,
    input  logic [VW-1:0]    src3_in,
    output form_e            form,
    output logic [LANES-1:0] act,
    output logic [LANES-1:0] need,
    output logic [1:0]       rm,
    output logic [VW-1:0]    src3_eff
);

    logic use_bcast;
    logic rc_override;

    assign form        = form_of(form_code);
    assign use_bcast   = mem_src & bcast;
    assign rc_override = ~mem_src & bcast & (vlen_sel == VL_512);
    assign rm          = rc_override ? rc_embed : rc_global;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign act[i]  = (i < int'(lanes_of(vlen_sel)));
        assign need[i] = act[i] & (~mask_en | mask[i]);
        assign src3_eff[i*LW +: LW] = use_bcast ? src3_in[LW-1:0] : src3_in[i*LW +: LW];
    end

endmodule

// File: rtl/vfma_lane_route.sv
module vfma_lane_route
    import vfma_pkg::*;
#(
    parameter int LANES = 8,
    parameter int LW    = 64,
    localparam int VW   = LANES * LW
) (
    input  form_e            form,
    input  logic             en,
    input  logic [LANES-1:0] need,
    input  logic [VW-1:0]    dst,
    input  logic [VW-1:0]    src2,
    input  logic [VW-1:0]    src3,
    output logic [VW-1:0]    op_a,
    output logic [VW-1:0]    op_b,
    output logic [VW-1:0]    op_c
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LW-1:0] d, s2, s3;
        logic [LW-1:0] a, b, c;
        logic          on;

        assign d  = dst[i*LW +: LW];
        assign s2 = src2[i*LW +: LW];
        assign s3 = src3[i*LW +: LW];
        assign on = en & need[i];

        always_comb begin
            case (form)
                FM_213:  begin a = s2; b = d;  c = s3; end
                FM_231:  begin a = s2; b = s3; c = d;  end
                default: begin a = d;  b = s3; c = s2; end
            endcase
        end

        assign op_a[i*LW +: LW] = on ? a : '0;
        assign op_b[i*LW +: LW] = on ? b : '0;
        assign op_c[i*LW +: LW] = on ? c : '0;
    end

endmodule

// File: rtl/vfma_merge.sv
module vfma_merge #(
    parameter int LANES = 8,
    parameter int LW    = 64,
    localparam int VW   = LANES * LW
) (
    input  logic [LANES-1:0] act,
    input  logic [LANES-1:0] need,
    input  logic             zero_mode,
    input  logic [VW-1:0]    old_val,
    input  logic [VW-1:0]    res,
    output logic [VW-1:0]    merged
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            if (!act[i])
                merged[i*LW +: LW] = '0;
            else if (need[i])
                merged[i*LW +: LW] = res[i*LW +: LW];
            else if (zero_mode)
                merged[i*LW +: LW] = '0;
            else
                merged[i*LW +: LW] = old_val[i*LW +: LW];
        end
    end

endmodule

// File: rtl/vfma_steer_wb.sv
module vfma_steer_wb
    import vfma_pkg::*;
#(
    parameter int LANES = 8,
    parameter int LW    = 64,
    localparam int VW   = LANES * LW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [7:0]       form_code,
    input  logic [1:0]       vlen_sel,
    input  logic [VW-1:0]    dst_in,
    input  logic [VW-1:0]    src2_in,
    input  logic [VW-1:0]    src3_in,
    input  logic             bcast,
    input  logic             mem_src,
    input  logic [LANES-1:0] mask,
    input  logic             mask_en,
    input  logic             zero_mode,
    input  logic [1:0]       rc_embed,
    input  logic [1:0]       rc_global,
    output logic [LANES-1:0] lane_go,
    output logic [VW-1:0]    lane_a,
    output logic [VW-1:0]    lane_b,
    output logic [VW-1:0]    lane_c,
    output logic [1:0]       lane_rm,
    input  logic [VW-1:0]    lane_res,
    input  logic [LANES-1:0] lane_res_vld,
    output logic             done,
    output logic [VW-1:0]    dst_out
);

    form_e            form_d;
    logic [LANES-1:0] act_d, need_d;
    logic [1:0]       rm_d;
    logic [VW-1:0]    src3_d;

    ctx_t             ctx_q;
    logic             busy_q;
    logic [LANES-1:0] act_q, need_q, got_q, go_q;
    logic [VW-1:0]    dst_q, src2_q, src3_q, res_q;

    logic             accept;
    logic [LANES-1:0] arrive;
    logic             complete;
    logic [VW-1:0]    res_now, merged;

    vfma_req_decode #(.LANES(LANES), .LW(LW)) dec_i (
        .form_code (form_code),
        .vlen_sel  (vlen_sel),
        .bcast     (bcast),
        .mem_src   (mem_src),
        .mask      (mask),
        .mask_en   (mask_en),
        .rc_embed  (rc_embed),
        .rc_global (rc_global),
        .src3_in   (src3_in),
        .form      (form_d),
        .act       (act_d),
        .need      (need_d),
        .rm        (rm_d),
        .src3_eff  (src3_d)
    );

    vfma_lane_route #(.LANES(LANES), .LW(LW)) route_i (
        .form (ctx_q.form),
        .en   (busy_q),
        .need (need_q),
        .dst  (dst_q),
        .src2 (src2_q),
        .src3 (src3_q),
        .op_a (lane_a),
        .op_b (lane_b),
        .op_c (lane_c)
    );

    vfma_merge #(.LANES(LANES), .LW(LW)) merge_i (
        .act       (act_q),
        .need      (need_q),
        .zero_mode (ctx_q.zero_mode),
        .old_val   (dst_q),
        .res       (res_now),
        .merged    (merged)
    );

    assign req_ready = ~busy_q;
    assign accept    = req_valid & ~busy_q;
    assign arrive    = busy_q ? (lane_res_vld & need_q & ~got_q) : '0;
    assign complete  = busy_q & ((got_q | arrive) == need_q);
    assign lane_go   = go_q;
    assign lane_rm   = ctx_q.rm;

    for (genvar i = 0; i < LANES; i++) begin : g_res
        assign res_now[i*LW +: LW] = got_q[i] ? res_q[i*LW +: LW] : lane_res[i*LW +: LW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            ctx_q   <= '{form: FM_132, zero_mode: 1'b0, rm: 2'b00};
            act_q   <= '0;
            need_q  <= '0;
            got_q   <= '0;
            go_q    <= '0;
            dst_q   <= '0;
            src2_q  <= '0;
            src3_q  <= '0;
            res_q   <= '0;
            done    <= 1'b0;
            dst_out <= '0;
        end else begin
            done <= 1'b0;
            go_q <= '0;
            if (accept) begin
                busy_q  <= 1'b1;
                ctx_q   <= '{form: form_d, zero_mode: zero_mode, rm: rm_d};
                act_q   <= act_d;
                need_q  <= need_d;
                got_q   <= '0;
                go_q    <= need_d;
                dst_q   <= dst_in;
                src2_q  <= src2_in;
                src3_q  <= src3_d;
            end else if (busy_q) begin
                for (int i = 0; i < LANES; i++) begin
                    if (arrive[i]) res_q[i*LW +: LW] <= lane_res[i*LW +: LW];
                end
                got_q <= got_q | arrive;
                if (complete) begin
                    busy_q  <= 1'b0;
                    done    <= 1'b1;
                    dst_out <= merged;
                end
            end
        end
    end

endmodule

// File: rtl/vfma_steer_wb_chk.sv
module vfma_steer_wb_chk #(
    parameter int LANES = 8,
    parameter int LW    = 64,
    localparam int VW   = LANES * LW
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [7:0]       form_code,
    input logic [1:0]       vlen_sel,
    input logic [LANES-1:0] lane_go,
    input logic [1:0]       lane_rm,
    input logic             done,
    input logic [VW-1:0]    dst_out,
    input logic [LANES-1:0] act_q
);

    logic [VW-1:0] hi_mask;
    for (genvar i = 0; i < LANES; i++) begin : g_hi
        assign hi_mask[i*LW +: LW] = act_q[i] ? '0 : '1;
    end

    // R4: accepted requests carry a legal length and form
    assert_legal_req_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |->
            (vlen_sel != 2'b11) &&
            (form_code == 8'h98 || form_code == 8'hA8 || form_code == 8'hB8));

    assert_issue_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        (|lane_go) |=> (lane_go == '0));

    assert_issue_active_R6: assert property (@(posedge clk) disable iff (rst)
        (lane_go & ~act_q) == '0);

    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> ((dst_out & hi_mask) == '0));

    assert_ready_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> req_ready);

    assert_rm_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && $past(!req_ready)) |-> $stable(lane_rm));

endmodule

bind vfma_steer_wb vfma_steer_wb_chk #(.LANES(LANES), .LW(LW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .form_code (form_code),
    .vlen_sel  (vlen_sel),
    .lane_go   (lane_go),
    .lane_rm   (lane_rm),
    .done      (done),
    .dst_out   (dst_out),
    .act_q     (act_q)
);

// File: tb/vfma_steer_wb_tb.sv
module vfma_steer_wb_tb_top;

    localparam int LANES = 8;
    localparam int LW    = 64;
    localparam int VW    = LANES * LW;
    localparam int NV    = 10;

    // entry: [26:19] form, [18:17] vlen, [16] bcast, [15] mem, [14] mask_en,
    //        [13] zero, [12] stagger, [11:4] mask, [3:2] rc_embed, [1:0] rc_global
    localparam logic [26:0] VEC [NV] = '{
        {8'h98, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 2'd2, 2'd1},
        {8'hA8, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hA5, 2'd0, 2'd3},
        {8'hB8, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFE, 2'd1, 2'd2},
        {8'h98, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 2'd2, 2'd1},
        {8'hA8, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h3C, 2'd3, 2'd0},
        {8'hB8, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 2'd3, 2'd1},
        {8'h98, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 2'd1, 2'd2},
        {8'hB8, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h81, 2'd0, 2'd2},
        {8'hA8, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 2'd3, 2'd1},
        {8'h98, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 2'd0, 2'd3}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [7:0]       form_code = 8'h98;
    logic [1:0]       vlen_sel = 2'b00;
    logic [VW-1:0]    dst_in = '0, src2_in = '0, src3_in = '0;
    logic             bcast = 1'b0, mem_src = 1'b0;
    logic [LANES-1:0] mask = '0;
    logic             mask_en = 1'b0, zero_mode = 1'b0;
    logic [1:0]       rc_embed = '0, rc_global = '0;
    logic [LANES-1:0] lane_go;
    logic [VW-1:0]    lane_a, lane_b, lane_c;
    logic [1:0]       lane_rm;
    logic [VW-1:0]    lane_res = '0;
    logic [LANES-1:0] lane_res_vld = '0;
    logic             done;
    logic [VW-1:0]    dst_out;

    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    vfma_steer_wb #(.LANES(LANES), .LW(LW)) dut_i (.*);

    task automatic check(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] gen(input int tag, input int k, input int i);
        return {8'(tag), 8'(k), 8'(i), 8'h5A, 32'(k * 131 + i * 17 + tag * 7)};
    endfunction

    // stand-in for the lane arithmetic
    function automatic logic [LW-1:0] fmodel(input logic [LW-1:0] a, input logic [LW-1:0] b,
                                             input logic [LW-1:0] c, input logic [1:0] rm);
        return (a * 64'd3) + (b << 5) + ~c + {62'd0, rm};
    endfunction

    task automatic run_vec(input logic [26:0] e, input int k, input bit poke);
        logic [7:0] f    = e[26:19];
        logic [1:0] vl   = e[18:17];
        logic       bc   = e[16];
        logic       ms   = e[15];
        logic       men  = e[14];
        logic       zm   = e[13];
        logic       stg  = e[12];
        logic [7:0] mk   = e[11:4];
        logic [1:0] rce  = e[3:2];
        logic [1:0] rcg  = e[1:0];
        logic [VW-1:0] d, s2, s3, ea, eb, ec, eo;
        logic [LANES-1:0] need, rem, pres;
        logic [1:0] erm;
        int cnt;
        cnt = (vl == 2'd0) ? 2 : (vl == 2'd1) ? 4 : 8;
        for (int i = 0; i < LANES; i++) begin
            d[i*LW +: LW]  = gen(1, k, i);
            s2[i*LW +: LW] = gen(2, k, i);
            s3[i*LW +: LW] = gen(3, k, i);
        end
        erm = (!ms && bc && vl == 2'd2) ? rce : rcg;   // R8
        for (int i = 0; i < LANES; i++) begin
            logic [LW-1:0] x3, a, b, c;
            need[i] = (i < cnt) && (!men || mk[i]);       // R4, R12
            x3 = (ms && bc) ? s3[LW-1:0] : s3[i*LW +: LW]; // R7
            case (f)
                8'hA8:   begin a = s2[i*LW +: LW]; b = d[i*LW +: LW]; c = x3; end  // R2
                8'hB8:   begin a = s2[i*LW +: LW]; b = x3; c = d[i*LW +: LW]; end  // R3
                default: begin a = d[i*LW +: LW]; b = x3; c = s2[i*LW +: LW]; end  // R1
            endcase
            ea[i*LW +: LW] = need[i] ? a : '0;
            eb[i*LW +: LW] = need[i] ? b : '0;
            ec[i*LW +: LW] = need[i] ? c : '0;
            if (i >= cnt)     eo[i*LW +: LW] = '0;                       // R6
            else if (need[i]) eo[i*LW +: LW] = fmodel(a, b, c, erm);
            else if (zm)      eo[i*LW +: LW] = '0;                       // R5
            else              eo[i*LW +: LW] = d[i*LW +: LW];
        end

        @(negedge clk);
        form_code = f; vlen_sel = vl; bcast = bc; mem_src = ms; mask_en = men;
        zero_mode = zm; mask = mk; rc_embed = rce; rc_global = rcg;
        dst_in = d; src2_in = s2; src3_in = s3; req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        check(lane_go == need, "R4 lane_go", VW'(lane_go), VW'(need));
        check(lane_rm == erm, "R8 lane_rm", VW'(lane_rm), VW'(erm));
        check(lane_a == ea, "R1 R2 R3 multiplicand", lane_a, ea);
        check(lane_b == eb, "R1 R2 R3 R7 multiplier", lane_b, eb);
        check(lane_c == ec, "R1 R2 R3 R7 addend", lane_c, ec);
        check(req_ready == 1'b0, "R9 busy", VW'(req_ready), '0);

        rem = need;
        do begin
            pres = stg ? (rem & (~rem + 8'd1)) : rem;
            for (int i = 0; i < LANES; i++) begin
                lane_res[i*LW +: LW] = pres[i] ?
                    fmodel(lane_a[i*LW +: LW], lane_b[i*LW +: LW], lane_c[i*LW +: LW], lane_rm) :
                    64'hDEAD_BEEF_0BAD_F00D ^ LW'(i);
            end
            lane_res_vld = pres | ~need;   // junk on non-issued lanes, R6
            if (poke) begin
                req_valid = 1'b1;
                dst_in = ~d;
                check(req_ready == 1'b0, "R9 ready low while busy", VW'(req_ready), '0);
            end
            @(posedge clk); #1;
            req_valid = 1'b0;
            rem = rem & ~pres;
            if (rem != '0)
                check(done == 1'b0, "R10 early done", VW'(done), '0);
        end while (rem != '0);
        lane_res_vld = '0;
        check(done == 1'b1, "R10 done", VW'(done), VW'(1));
        check(dst_out == eo, "R5 R6 R10 dst_out", dst_out, eo);
        @(posedge clk); #1;
        check(done == 1'b0, "R10 done pulse", VW'(done), '0);
        check(req_ready == 1'b1, "R9 ready after done", VW'(req_ready), VW'(1));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R11: reset state
        check(req_ready == 1'b1, "R11 ready", VW'(req_ready), VW'(1));
        check(done == 1'b0, "R11 done", VW'(done), '0);
        check(lane_go == '0, "R11 lane_go", VW'(lane_go), '0);
        check(dst_out == '0, "R11 dst_out", dst_out, '0);

        for (int k = 0; k < NV; k++) run_vec(VEC[k], k, 1'b0);

        // R9: request and destination changes while busy are ignored
        run_vec({8'hA8, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h06, 2'd0, 2'd1}, 20, 1'b1);
        // R12: mask bits above 128-bit length ignored, merge kept
        run_vec({8'hB8, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFC, 2'd0, 2'd0}, 21, 1'b0);
        // back-to-back after a no-issue request
        run_vec({8'h98, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 2'd0, 2'd0}, 22, 1'b0);
        run_vec({8'hB8, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 2'd3, 2'd0}, 23, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule